// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under a one-bit-per-element mask. Element i counts as active when mask bit i is 1. In compress mode the active elements of the source vector are gathered into the low lanes of the result, keeping their relative order. In expand mode the low lanes of the source are scattered out to the active positions. Lanes that are not active in expand mode take the element at the same index of a second fill vector. The number of active elements is reported alongside the result in both modes.

One operand set is taken per transaction through a valid/ready handshake. The result, together with its count, is registered. It appears on the cycle after acceptance and is held until the consumer takes it. Element width and vector length are parameters. Lane i of any vector occupies bits [i*ELEM_W +: ELEM_W].

Top module: `vcx_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_mode`=0 (compress), active source lanes are written to result lanes 0, 1, 2, ... in increasing source index order.
- R3: In compress mode, result lanes at or above the active count are 0.
- R4: `out_len` equals the number of set bits in the accepted mask, in both modes.
- R5: With `in_mode`=1 (expand), the k-th set mask position (counting from lane 0) receives source lane k.
- R6: In expand mode, each lane whose mask bit is 0 receives the fill vector's lane of the same index.
- R7: An all-zero mask gives `out_len`=0. Compress then returns all zeros, and expand returns the fill vector unchanged.
- R8: An operand set accepted at a clock edge (`in_valid` and `in_ready` both 1) raises `out_valid` at that edge, with its result on `out_vec`/`out_len`. A result taken with `out_ready`=1 drops `out_valid` at the next edge.
- R9: While `out_valid`=1 and `out_ready`=0, `out_vec` and `out_len` hold their values and `in_ready` is 0. Operands offered during that time are not taken.
- R10: An all-ones mask passes the source through unchanged in both modes, with `out_len`=VLEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_mode | input | 1 | 0 compress, 1 expand |
| in_mask | input | VLEN | Element mask, bit i for lane i |
| in_src | input | VLEN*ELEM_W | Source vector |
| in_fill | input | VLEN*ELEM_W | Fill vector for inactive expand lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | VLEN*ELEM_W | Result vector |
| out_len | output | $clog2(VLEN+1) | Active element count |

## Verification
The bench targets sparse, alternating, single-bit, empty and full masks in both modes. An off-by-one in the running rank would shift packed lanes or pick the wrong source lane, and a design that skipped the fill path would leak source data into inactive expand lanes. For the empty mask, a missing zero fill would leave stale data above the count, and a broken expand would not return the fill vector intact. The bench also holds back `out_ready` while it offers new operands. A design that overwrote its pending result, or took those operands, would change `out_vec` or produce an extra result.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  typedef enum logic {
    VCX_PACK   = 1'b0,
    VCX_SPREAD = 1'b1
  } vcx_mode_e;
endpackage

// File: rtl/vcx_rank.sv
// Exclusive prefix count of the mask: rank of each lane among the active ones.
module vcx_rank #(
  parameter int VLEN  = 8,
  parameter int CNT_W = $clog2(VLEN + 1)
) (
  input  logic [VLEN-1:0]       mask,
  output logic [VLEN*CNT_W-1:0] rank_flat,
  output logic [CNT_W-1:0]      total
);
  logic [CNT_W-1:0] run [VLEN+1];

  assign run[0] = '0;
  for (genvar i = 0; i < VLEN; i++) begin : g_chain
    assign run[i+1] = run[i] + CNT_W'(mask[i]);
    assign rank_flat[i*CNT_W +: CNT_W] = run[i];
  end
  assign total = run[VLEN];
endmodule

// File: rtl/vcx_pack.sv
// Compress: result lane j takes the active source lane whose rank is j.
module vcx_pack #(
  parameter int ELEM_W = 8,
  parameter int VLEN   = 8,
  parameter int CNT_W  = $clog2(VLEN + 1)
) (
  input  logic [VLEN*ELEM_W-1:0] src,
  input  logic [VLEN-1:0]        mask,
  input  logic [VLEN*CNT_W-1:0]  rank_flat,
  output logic [VLEN*ELEM_W-1:0] dst
);
  for (genvar j = 0; j < VLEN; j++) begin : g_lane
    logic [ELEM_W-1:0] lane;
    always_comb begin
      lane = '0;
      for (int i = j; i < VLEN; i++) begin
        if (mask[i] && (rank_flat[i*CNT_W +: CNT_W] == CNT_W'(j)))
          lane = src[i*ELEM_W +: ELEM_W];
      end
    end
    assign dst[j*ELEM_W +: ELEM_W] = lane;
  end
endmodule

// File: rtl/vcx_spread.sv
// Expand: active lane i takes source lane rank(i); inactive lanes take fill.
module vcx_spread #(
  parameter int ELEM_W = 8,
  parameter int VLEN   = 8,
  parameter int CNT_W  = $clog2(VLEN + 1)
) (
  input  logic [VLEN*ELEM_W-1:0] src,
  input  logic [VLEN*ELEM_W-1:0] fill,
  input  logic [VLEN-1:0]        mask,
  input  logic [VLEN*CNT_W-1:0]  rank_flat,
  output logic [VLEN*ELEM_W-1:0] dst
);
  for (genvar i = 0; i < VLEN; i++) begin : g_lane
    logic [ELEM_W-1:0] lane;
    always_comb begin
      lane = fill[i*ELEM_W +: ELEM_W];
      if (mask[i]) begin
        for (int k = 0; k <= i; k++) begin
          if (rank_flat[i*CNT_W +: CNT_W] == CNT_W'(k))
            lane = src[k*ELEM_W +: ELEM_W];
        end
      end
    end
    assign dst[i*ELEM_W +: ELEM_W] = lane;
  end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit
  import vcx_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int VLEN   = 8,
  localparam int CNT_W = $clog2(VLEN + 1),
  localparam int VEC_W = VLEN * ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic [VLEN-1:0]  in_mask,
  input  logic [VEC_W-1:0] in_src,
  input  logic [VEC_W-1:0] in_fill,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic [CNT_W-1:0] out_len
);
  logic [VLEN*CNT_W-1:0] rank_flat;
  logic [CNT_W-1:0]      cnt;
  logic [VEC_W-1:0]      pack_vec, spread_vec, sel_vec;
  vcx_mode_e             mode;

  assign mode = vcx_mode_e'(in_mode);

  vcx_rank #(.VLEN(VLEN), .CNT_W(CNT_W)) u_rank (
    .mask(in_mask), .rank_flat(rank_flat), .total(cnt)
  );

  vcx_pack #(.ELEM_W(ELEM_W), .VLEN(VLEN), .CNT_W(CNT_W)) u_pack (
    .src(in_src), .mask(in_mask), .rank_flat(rank_flat), .dst(pack_vec)
  );

  vcx_spread #(.ELEM_W(ELEM_W), .VLEN(VLEN), .CNT_W(CNT_W)) u_spread (
    .src(in_src), .fill(in_fill), .mask(in_mask), .rank_flat(rank_flat),
    .dst(spread_vec)
  );

  assign sel_vec = (mode == VCX_SPREAD) ? spread_vec : pack_vec;

  // Handshake: one result slot, no new operands while it is occupied.
  logic accept, valid_d;

  assign in_ready = ~out_valid;
  assign accept   = in_valid & in_ready;

  always_comb begin
    valid_d = out_valid;
    if (out_valid) valid_d = ~out_ready;
    else           valid_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec <= '0;
      out_len <= '0;
    end else if (accept) begin
      out_vec <= sel_vec;
      out_len <= cnt;
    end
  end

  // Assertions
  a_r8_accept_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r8_drain_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_len)));

  a_r4_len_is_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_len == CNT_W'($countones($past(in_mask)))));

  for (genvar j = 0; j < VLEN; j++) begin : g_chk
    a_r3_zero_above_len: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mode == VCX_PACK) |=>
        ((out_len > CNT_W'(j)) || (out_vec[j*ELEM_W +: ELEM_W] == '0)));

    a_r6_fill_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mode == VCX_SPREAD && !in_mask[j]) |=>
        (out_vec[j*ELEM_W +: ELEM_W] == $past(in_fill[j*ELEM_W +: ELEM_W])));
  end
endmodule

// File: tb/vcx_unit_tb.sv
module vcx_unit_tb;
  localparam int EW = 8;
  localparam int VL = 8;
  localparam int CW = 4;
  localparam int NT = 10;

  // Stimulus table: mode, mask, hand-counted active length.
  localparam logic       T_MODE [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                         1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [7:0] T_MASK [NT] = '{8'b1011_0010, 8'b1011_0010, 8'hFF, 8'hFF,
                                         8'h00, 8'h00, 8'h80, 8'h01,
                                         8'b0101_0101, 8'b0101_0101};
  localparam logic [3:0] T_LEN  [NT] = '{4'd4, 4'd4, 4'd8, 4'd8, 4'd0,
                                         4'd0, 4'd1, 4'd1, 4'd4, 4'd4};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid, in_ready, in_mode, out_valid, out_ready;
  logic [VL-1:0]  in_mask;
  logic [VL*EW-1:0] in_src, in_fill, out_vec;
  logic [CW-1:0]  out_len;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vcx_unit #(.ELEM_W(EW), .VLEN(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_mask(in_mask), .in_src(in_src), .in_fill(in_fill),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .out_len(out_len)
  );

  function automatic logic [VL*EW-1:0] model(input logic mode, input logic [VL-1:0] m,
                                             input logic [VL*EW-1:0] s,
                                             input logic [VL*EW-1:0] f);
    logic [VL*EW-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < VL; i++) begin
      if (!mode) begin
        if (m[i]) begin r[k*EW +: EW] = s[i*EW +: EW]; k++; end
      end else begin
        if (m[i]) begin r[i*EW +: EW] = s[k*EW +: EW]; k++; end
        else r[i*EW +: EW] = f[i*EW +: EW];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic offer(input logic mode, input logic [VL-1:0] m,
                       input logic [VL*EW-1:0] s, input logic [VL*EW-1:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_mask = m; in_src = s; in_fill = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 drop", {63'd0, out_valid}, 64'd0);
  endtask

  logic [VL*EW-1:0] src_a, fill_a, src_b, fill_b, held;

  initial begin
    for (int i = 0; i < VL; i++) begin
      src_a[i*EW +: EW]  = 8'hA0 + 8'(i);
      fill_a[i*EW +: EW] = 8'hB0 + 8'(i);
      src_b[i*EW +: EW]  = 8'h10 + 8'(i * 3);
      fill_b[i*EW +: EW] = 8'hC0 + 8'(i);
    end
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_mask = '0;
    in_src = '0; in_fill = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", {63'd0, in_ready}, 64'd1);

    // Table walk: R2 R3 R4 R5 R6 R7 R10
    for (int t = 0; t < NT; t++) begin
      offer(T_MODE[t], T_MASK[t], src_a, fill_a);
      check("R8 valid", {63'd0, out_valid}, 64'd1);
      check(T_MODE[t] ? "R5 R6 R7 R10 expand data" : "R2 R3 R7 R10 compress data",
            out_vec, model(T_MODE[t], T_MASK[t], src_a, fill_a));
      check("R4 R7 len", {60'd0, out_len}, {60'd0, T_LEN[t]});
      drain();
    end

    // R3 explicit: compress one active lane, upper lanes zero
    offer(1'b0, 8'b0000_0100, src_b, fill_b);
    check("R2 R3 single", out_vec, {56'd0, src_b[2*EW +: EW]});
    drain();

    // R6 explicit: expand lane pattern with mixed fill
    offer(1'b1, 8'b0000_0110, src_b, fill_b);
    check("R5 R6 mixed", out_vec,
          {fill_b[63:24], src_b[15:8], src_b[7:0], fill_b[7:0]});
    drain();

    // R9 hold while stalled, new operands refused
    offer(1'b0, 8'b1100_0011, src_b, fill_b);
    held = out_vec;
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b1; in_mask = 8'hFF; in_src = src_a; in_fill = fill_a;
    check("R9 ready low", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check("R9 held data", out_vec, held);
    check("R9 held len", {60'd0, out_len}, 64'd4);
    check("R9 still valid", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    drain();
    @(negedge clk);
    check("R9 offer not taken", {63'd0, out_valid}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule